// File: doc/BRIEF.md
# Interrupt Status and Mask Unit for an I2C Packet Engine

This unit gathers eight event sources from an I2C packet engine into one status register. Six of the sources are discrete events: packet transfer complete, all packets complete, transmit overflow, receive underflow, missing acknowledge and lost arbitration. They latch until software writes a one to the bit to clear it. The other two are the transmit and receive FIFO data requests. These are levels: the status bit follows the request and a clear write has no effect on it.

A mask register of the same layout selects which status bits may raise the single interrupt output. The packet-complete bit always interrupts, whatever its mask bit holds. The interrupt line is registered. Alongside the status register, the unit keeps a two-bit error summary for the transfer in progress. A start pulse clears the summary, and missing-acknowledge or lost-arbitration events accumulate into it.

Software reaches the status and mask through a small register port. Writes take effect on the clock edge, and reads are combinational.

Top module: `i2c_irq_status`

## Requirements
- R1: The status register bit positions are: 7 packet transfer complete, 6 all packets complete, 5 transmit overflow, 4 receive underflow, 3 no acknowledge, 2 arbitration lost, 1 transmit data request, 0 receive data request. A one-cycle pulse on `ev_i[b]` for b in 7..2 sets status bit b at the next clock edge, and the bit stays set after the pulse ends.
- R2: A write to address 0 (status) clears every sticky status bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R3: If an event on a sticky bit and a clear write to that same bit fall in the same cycle, the bit is set after the edge.
- R4: Status bits 1 and 0 equal `ev_i[1]` and `ev_i[0]` as sampled at the previous clock edge. A clear write to these bits leaves them unchanged.
- R5: The mask register sits at address 1, uses the status bit layout, and reads back the value last written. A mask bit of 1 enables that source.
- R6: `irq_o` is registered. It is 1 in the cycle after the status register holds any bit that is set and also enabled by the mask, and 0 in the cycle after no enabled bit is set.
- R7: Status bit 7 drives `irq_o` even when mask bit 7 is 0.
- R8: `err_o[0]` records a no-acknowledge event and `err_o[1]` records a lost-arbitration event since the last `xfer_start_i` pulse. A start pulse clears both bits, but an error event in the same cycle as the start still sets its bit.
- R9: After reset, the status, mask, `irq_o` and `err_o` are all zero.
- R10: A read of any address other than 0 or 1 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_i | input | 8 | Event pulses (bits 7..2) and FIFO request levels (bits 1..0) |
| xfer_start_i | input | 1 | Pulse marking the start of a new transfer |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W (2) | Register address |
| reg_wdata_i | input | DATA_W (32) | Register write data |
| reg_rdata_o | output | DATA_W (32) | Register read data, combinational from the address |
| irq_o | output | 1 | Interrupt request, registered |
| err_o | output | 2 | Error summary: bit 1 arbitration lost, bit 0 no acknowledge |

## Verification
Two collisions can fall in the same cycle. The first is an engine event on a sticky bit meeting a software clear of that bit. The bench drives the event pulse and the clear write on the same falling edge and expects the bit to read as set afterward. The second is a transfer start meeting an arbitration-lost event. The bench raises both together and expects only the arbitration bit of the error summary to remain. The bench also sweeps all 256 mask values against every source, which covers the case where a masked bit 7 still interrupts. That case is judged against an expected interrupt computed arithmetically from the mask and the bit index.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
   localparam int SRC_N        = 8;
   localparam int BIT_PKT_DONE = 7;
   localparam int BIT_ALL_DONE = 6;
   localparam int BIT_TX_OVF   = 5;
   localparam int BIT_RX_UDF   = 4;
   localparam int BIT_NACK     = 3;
   localparam int BIT_ARB      = 2;
   localparam int BIT_TX_REQ   = 1;
   localparam int BIT_RX_REQ   = 0;
   localparam int ERR_N        = 2;
   localparam int ERR_NACK     = 0;
   localparam int ERR_ARB      = 1;
   typedef logic [SRC_N-1:0] src_vec_t;
   typedef logic [ERR_N-1:0] err_vec_t;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell #(
   parameter bit LEVEL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ev_i,
   input  logic clr_i,
   output logic q_o
);
   logic q_q;

   generate
      if (LEVEL) begin : g_level
         logic unused_clr;
         assign unused_clr = clr_i;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) q_q <= 1'b0;
            else         q_q <= ev_i;
         end
         AST_LEVEL_HI: assert property (@(posedge clk_i) disable iff (!rst_ni) ev_i |=> q_o);    // R4
         AST_LEVEL_LO: assert property (@(posedge clk_i) disable iff (!rst_ni) !ev_i |=> !q_o);  // R4
      end else begin : g_sticky
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) q_q <= 1'b0;
            else         q_q <= ev_i | (q_q & ~clr_i);
         end
         AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni) ev_i |=> q_o);                  // R3
         AST_STICKY:   assert property (@(posedge clk_i) disable iff (!rst_ni) (q_o && !clr_i) |=> q_o);       // R1
         AST_W1C:      assert property (@(posedge clk_i) disable iff (!rst_ni) (clr_i && !ev_i) |=> !q_o);     // R2
      end
   endgenerate

   assign q_o = q_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_i,
   input  logic [WIDTH-1:0] wdata_i,
   output logic [WIDTH-1:0] mask_o
);
   logic [WIDTH-1:0] mask_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   mask_q <= '0;
      else if (wr_i) mask_q <= wdata_i;
   end

   assign mask_o = mask_q;

   AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_i |=> mask_o == $past(wdata_i)); // R5
   AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !wr_i |=> $stable(mask_o));        // R5
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
   parameter int               WIDTH      = 8,
   parameter logic [WIDTH-1:0] BYPASS     = 8'h80,
   parameter bit               REGISTERED = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] status_i,
   input  logic [WIDTH-1:0] mask_i,
   output logic             irq_o
);
   logic [WIDTH-1:0] enabled;
   logic             irq_d;

   assign enabled = status_i & (mask_i | BYPASS);
   assign irq_d   = |enabled;

   generate
      if (REGISTERED) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) irq_q <= 1'b0;
            else         irq_q <= irq_d;
         end
         assign irq_o = irq_q;
         AST_BYPASS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ((status_i & BYPASS) != '0) |=> irq_o);                                    // R7
         AST_MASKED_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ((status_i & mask_i) != '0) |=> irq_o);                                    // R6
         AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ((status_i & (mask_i | BYPASS)) == '0) |=> !irq_o);                        // R6
      end else begin : g_comb
         assign irq_o = irq_d;
      end
   endgenerate
endmodule

// File: rtl/irq_err_track.sv
module irq_err_track (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic nack_i,
   input  logic arb_i,
   output logic [1:0] err_o
);
   import i2c_irq_pkg::*;
   err_vec_t err_q, err_hit;

   always_comb begin
      err_hit           = '0;
      err_hit[ERR_NACK] = nack_i;
      err_hit[ERR_ARB]  = arb_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) err_q <= '0;
      else         err_q <= (start_i ? '0 : err_q) | err_hit;
   end

   assign err_o = err_q;

   AST_ERR_NACK:  assert property (@(posedge clk_i) disable iff (!rst_ni) nack_i |=> err_o[ERR_NACK]);                          // R8
   AST_ERR_ARB:   assert property (@(posedge clk_i) disable iff (!rst_ni) arb_i |=> err_o[ERR_ARB]);                            // R8
   AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni) (start_i && !nack_i && !arb_i) |=> err_o == '0);      // R8
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status #(
   parameter int   DATA_W      = 32,
   parameter int   ADDR_W      = 2,
   parameter int   STATUS_ADDR = 0,
   parameter int   MASK_ADDR   = 1,
   parameter logic [7:0] LEVEL_BITS  = 8'h03,
   parameter logic [7:0] BYPASS_BITS = 8'h80,
   parameter bit   IRQ_REG     = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [7:0]        ev_i,
   input  logic              xfer_start_i,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              irq_o,
   output logic [1:0]        err_o
);
   import i2c_irq_pkg::*;

   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STATUS_ADDR);
   localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(MASK_ADDR);

   generate
      if (DATA_W < SRC_N) begin : g_bad_width
         $error("DATA_W must hold all status bits");
      end
      if (STATUS_ADDR == MASK_ADDR) begin : g_bad_addr
         $error("status and mask addresses must differ");
      end
      if ((LEVEL_BITS & BYPASS_BITS) != '0) begin : g_bad_bypass
         $error("a level source may not bypass the mask");
      end
      if (DATA_W > SRC_N) begin : g_hi_bits
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:SRC_N];
      end
   endgenerate

   src_vec_t status, mask, clr_vec, wdata_lo;
   logic     wr_status, wr_mask;

   assign wdata_lo  = reg_wdata_i[SRC_N-1:0];
   assign wr_status = reg_wr_i && (reg_addr_i == A_STATUS);
   assign wr_mask   = reg_wr_i && (reg_addr_i == A_MASK);
   assign clr_vec   = wr_status ? wdata_lo : '0;

   generate
      for (genvar i = 0; i < SRC_N; i++) begin : g_src
         irq_src_cell #(.LEVEL(LEVEL_BITS[i])) u_cell (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .ev_i  (ev_i[i]),
            .clr_i (clr_vec[i]),
            .q_o   (status[i])
         );
      end
   endgenerate

   irq_mask_reg #(.WIDTH(SRC_N)) u_mask (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr_mask),
      .wdata_i(wdata_lo),
      .mask_o (mask)
   );

   irq_merge #(.WIDTH(SRC_N), .BYPASS(BYPASS_BITS), .REGISTERED(IRQ_REG)) u_merge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .status_i(status),
      .mask_i  (mask),
      .irq_o   (irq_o)
   );

   irq_err_track u_err (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(xfer_start_i),
      .nack_i (ev_i[BIT_NACK]),
      .arb_i  (ev_i[BIT_ARB]),
      .err_o  (err_o)
   );

   always_comb begin
      reg_rdata_o = '0;
      if (reg_addr_i == A_STATUS)    reg_rdata_o[SRC_N-1:0] = status;
      else if (reg_addr_i == A_MASK) reg_rdata_o[SRC_N-1:0] = mask;
   end

   AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(rst_ni) |-> (status == '0 && !irq_o)); // R9
endmodule

// File: tb/i2c_irq_status_tb_top.sv
`timescale 1ns/1ps
module i2c_irq_status_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  ev;
   logic        start;
   logic        wr;
   logic [1:0]  addr;
   logic [31:0] wdata;
   logic [31:0] rdata;
   logic        irq;
   logic [1:0]  err;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   i2c_irq_status dut_i (
      .clk_i(clk), .rst_ni(rst_n), .ev_i(ev), .xfer_start_i(start),
      .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .irq_o(irq), .err_o(err)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic wreg(input logic [1:0] a, input logic [31:0] d);
      wr = 1'b1; addr = a; wdata = d;
      tick();
      wr = 1'b0; wdata = '0;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      rst_n = 1'b0; ev = '0; start = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
      repeat (3) @(negedge clk);
      rd(2'd0, d); check("R9 status", d, 0);
      rd(2'd1, d); check("R9 mask", d, 0);
      check("R9 irq", {31'b0, irq}, 0);
      check("R9 err", {30'b0, err}, 0);
      rst_n = 1'b1;
      tick();

      // sweep every mask value against every source
      for (int m = 0; m < 256; m++) begin
         wreg(2'd1, m);
         rd(2'd1, d); check("R5 mask readback", d, m);
         for (int b = 0; b < 8; b++) begin
            logic exp_irq;
            exp_irq = m[b] || (b == 7);
            if (b >= 2) begin
               ev = 8'(1 << b);
               tick();
               ev = '0;
               rd(2'd0, d); check("R1 sticky set", d, 1 << b);
               check("R6 irq latency", {31'b0, irq}, 0);
               tick();
               rd(2'd0, d); check("R1 sticky hold", d, 1 << b);
               check(b == 7 ? "R7 bypass irq" : "R6 masked irq", {31'b0, irq}, {31'b0, exp_irq});
               wreg(2'd0, 1 << b);
               rd(2'd0, d); check("R2 w1c", d, 0);
               tick();
               check("R6 irq drop", {31'b0, irq}, 0);
            end else begin
               ev = 8'(1 << b);
               tick();
               rd(2'd0, d); check("R4 level follow", d, 1 << b);
               tick();
               check("R6 level irq", {31'b0, irq}, {31'b0, exp_irq});
               wreg(2'd0, 1 << b);
               rd(2'd0, d); check("R4 clear ignored", d, 1 << b);
               ev = '0;
               tick();
               rd(2'd0, d); check("R4 level drop", d, 0);
               tick();
               check("R6 irq drop level", {31'b0, irq}, 0);
            end
         end
      end
      wreg(2'd1, 0);

      // R3: event and clear collide
      ev = 8'h20; wr = 1'b1; addr = 2'd0; wdata = 32'h20;
      tick();
      ev = '0; wr = 1'b0; wdata = '0;
      rd(2'd0, d); check("R3 set wins", d, 32'h20);
      wreg(2'd0, 32'h20);

      // R2: zero bits of a clear write leave bits alone
      ev = 8'h30;
      tick();
      ev = '0;
      wreg(2'd0, 32'h10);
      rd(2'd0, d); check("R2 partial clear", d, 32'h20);
      rd(2'd2, d); check("R10 addr2 zero", d, 0);
      rd(2'd3, d); check("R10 addr3 zero", d, 0);
      wreg(2'd0, 32'hFF);
      rd(2'd0, d); check("R2 clear all", d, 0);

      // R8: error summary
      start = 1'b1;
      tick();
      start = 1'b0;
      check("R8 start clears", {30'b0, err}, 0);
      ev = 8'h08;
      tick();
      ev = '0;
      check("R8 nack", {30'b0, err}, 1);
      ev = 8'h04;
      tick();
      ev = '0;
      check("R8 arb adds", {30'b0, err}, 3);
      start = 1'b1; ev = 8'h04;
      tick();
      start = 1'b0; ev = '0;
      check("R8 start with arb", {30'b0, err}, 2);
      start = 1'b1;
      tick();
      start = 1'b0;
      check("R8 final clear", {30'b0, err}, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule